// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Sequencer

This block is the device-side controller of a byte-wide nonvolatile memory model. A host drives a level write strobe with an address and a data byte. The block gathers one or more bytes into a page buffer, as long as every byte falls in the same page. When the host stops writing for a set number of cycles, the block copies the gathered bytes into its storage array. While it is loading or programming, the block shows a busy indication. During that time a read returns a status byte in place of array data: bit 7 is the inverse of bit 7 of the last accepted byte, and bit 6 flips on every status read. The host can therefore poll for completion over the data bus or watch the busy pin.

An active-low guard input stops all access. While the guard is low, reads and writes are dropped. If the guard goes low during a load or a programming period, that operation is aborted part-way. All time limits are parameters counted in clock cycles. The host interface uses plain strobes with no back-pressure. A read request always completes one cycle later, and a write is either accepted or silently dropped.

The array keeps `1 << STORE_W` bytes. The page number is taken from the full address for the same-page check, but the array index uses only the low `STORE_W` address bits.

Top module: `nvw_page_writer`

## Requirements
- R1: After reset, `busy_oe` is 0, `busy_lvl` is 1, `rd_valid` is 0 and `page_err` is 0.
- R2: A write strobe is `wr_en` high for one or more cycles and then low. The address is taken in the first cycle `wr_en` is high, and the data in the first cycle it is low again. A later change of `addr` inside the same strobe has no effect. When the block is idle and `guard_n` is high, the first byte opens a page, and `busy_oe` is 1 from the cycle after the strobe ends.
- R3: A page is 128 bytes, selected by `addr[16:7]`, and `addr[6:0]` is the byte index within it. Each accepted byte restarts a load timer. Programming begins `LOAD_WIN` cycles after the last accepted byte and lasts `PROG_CYC` cycles, so `busy_oe` returns to 0 exactly `LOAD_WIN + PROG_CYC` cycles after that byte.
- R4: After programming completes, a read returns each byte that was loaded into the page. Indices in the page that were not loaded keep their earlier contents.
- R5: While busy, bit 7 of the read data is the inverse of bit 7 of the last accepted byte.
- R6: While busy, bit 6 of the read data is 1 on the first status read after a page opens, and flips on each later status read. Bits 5:0 equal bits 5:0 of the last accepted byte.
- R7: A byte written while loading with a different `addr[16:7]` is dropped. It raises `page_err` for exactly one cycle and does not restart the load timer.
- R8: A write strobe that ends while programming is under way is ignored. It does not change the array, the status byte or the busy period.
- R9: While `guard_n` is low, `rd_req` produces no `rd_valid`, and a write strobe neither opens a page nor changes the array.
- R10: If `guard_n` goes low while busy, `busy_oe` is 0 on the following cycle. Bytes not yet copied keep their old array contents.
- R11: A read request with `guard_n` high yields `rd_valid` high, together with its data, in the next cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the controller |
| guard_n | input | 1 | Active-low access guard; low blocks access and aborts a busy operation |
| wr_en | input | 1 | Level write strobe |
| addr | input | 17 | Byte address for reads and writes |
| wdata | input | 8 | Write data, taken when the strobe ends |
| rd_req | input | 1 | One-cycle read request |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 8 | Array byte, or status byte while busy |
| busy_oe | output | 1 | Busy pin drive enable (1 while loading or programming) |
| busy_lvl | output | 1 | Busy pin level (0 when driven) |
| page_err | output | 1 | One-cycle pulse when a byte from another page is dropped |

## Verification
The assertions check the following on every cycle:
- programming never accepts a byte;
- a low guard always leaves the sequencer idle on the next cycle;
- an expired load timer always starts programming;
- an error pulse only follows a loading cycle;
- array writes happen only while busy;
- a valid read always follows a request by exactly one cycle.

Only the bench scenarios can show the rest:
- that the right data lands at the right array index;
- that the address and data are taken at opposite ends of the strobe;
- the exact length of the busy window, including after a dropped foreign byte;
- the sequence of status bytes;
- which bytes survive an abort.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } nvw_state_e;
endpackage

// File: rtl/nvw_strobe.sv
module nvw_strobe #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              commit
);
  logic wr_q;
  logic rise;

  assign rise   = wr_en & ~wr_q;
  assign commit = ~wr_en & wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      wr_q <= wr_en;
      if (rise) addr_q <= addr;
    end
  end

  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R2
endmodule

// File: rtl/nvw_pbuf.sv
module nvw_pbuf #(
  parameter int PAGE_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [PAGE_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PAGE_W-1:0] ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rmask
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [DATA_W-1:0]     buf_mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;

  always_ff @(posedge clk) begin
    if (we) buf_mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
    end else begin
      if (clr) mask <= '0;
      if (we)  mask[widx] <= 1'b1;
    end
  end

  assign rdata = buf_mem[ridx];
  assign rmask = mask[ridx];

  AST_FRESH_PAGE_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && we) |=> ($countones(mask) == 1)); // R3
endmodule

// File: rtl/nvw_array.sv
module nvw_array #(
  parameter int AW     = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/nvw_seq.sv
module nvw_seq
  import nvw_pkg::*;
#(
  parameter int PAGE_W    = 7,
  parameter int PAGENUM_W = 10,
  parameter int LOAD_WIN  = 5000,
  parameter int PROG_CYC  = 1000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 guard_n,
  input  logic                 commit,
  input  logic [PAGENUM_W-1:0] cpage,
  input  logic                 cur_mask,
  output logic                 busy,
  output logic                 acc,
  output logic                 start,
  output logic                 page_err,
  output logic                 prog_we,
  output logic [PAGE_W-1:0]    prog_idx,
  output logic [PAGENUM_W-1:0] page_q
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TW = $clog2(LOAD_WIN + 1);
  localparam int PW = $clog2(PROG_CYC + 1);

  nvw_state_e     state;
  logic [TW-1:0]  timer;
  logic [PW-1:0]  pcnt;
  logic           mis;

  assign busy     = (state != ST_IDLE);
  assign start    = commit && guard_n && (state == ST_IDLE);
  assign acc      = commit && guard_n &&
                    ((state == ST_IDLE) || ((state == ST_LOAD) && (cpage == page_q)));
  assign mis      = commit && guard_n && (state == ST_LOAD) && (cpage != page_q);
  assign prog_idx = pcnt[PAGE_W-1:0];
  assign prog_we  = guard_n && (state == ST_PROG) &&
                    (pcnt < PW'(PAGE_BYTES)) && cur_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      timer    <= '0;
      pcnt     <= '0;
      page_q   <= '0;
      page_err <= 1'b0;
    end else begin
      page_err <= mis;
      if (!guard_n) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (start) begin
              state  <= ST_LOAD;
              timer  <= '0;
              page_q <= cpage;
            end
          end
          ST_LOAD: begin
            if (acc) begin
              timer <= '0;
            end else if (timer == TW'(LOAD_WIN - 1)) begin
              state <= ST_PROG;
              pcnt  <= '0;
            end else begin
              timer <= timer + 1'b1;
            end
          end
          ST_PROG: begin
            if (pcnt == PW'(PROG_CYC - 1)) state <= ST_IDLE;
            else pcnt <= pcnt + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_PROG_TAKES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG) |-> !acc); // R8
  AST_GUARD_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !guard_n |=> (state == ST_IDLE)); // R10
  AST_WINDOW_STARTS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_n && state == ST_LOAD && !commit && timer == TW'(LOAD_WIN - 1))
      |=> (state == ST_PROG)); // R3
  AST_ERR_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |-> ($past(state) == ST_LOAD)); // R7
endmodule

// File: rtl/nvw_page_writer.sv
module nvw_page_writer #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 7,
  parameter int STORE_W  = 10,
  parameter int LOAD_WIN = 5000,
  parameter int PROG_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              guard_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy_oe,
  output logic              busy_lvl,
  output logic              page_err
);
  localparam int PAGENUM_W = ADDR_W - PAGE_W;
  localparam int SPAGE_W   = STORE_W - PAGE_W;

  logic [ADDR_W-1:0]    addr_q;
  logic                 commit;
  logic                 busy, acc, start, prog_we, cur_mask;
  logic [PAGE_W-1:0]    prog_idx;
  logic [PAGENUM_W-1:0] page_q;
  logic [DATA_W-1:0]    buf_rdata, arr_rdata, last_q, stat_q;
  logic                 tog_q, rd_stat, rd_go;

  nvw_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .addr_q(addr_q), .commit(commit)
  );

  nvw_seq #(
    .PAGE_W(PAGE_W), .PAGENUM_W(PAGENUM_W),
    .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .guard_n(guard_n), .commit(commit),
    .cpage(addr_q[ADDR_W-1:PAGE_W]), .cur_mask(cur_mask),
    .busy(busy), .acc(acc), .start(start), .page_err(page_err),
    .prog_we(prog_we), .prog_idx(prog_idx), .page_q(page_q)
  );

  nvw_pbuf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clr(start), .we(acc),
    .widx(addr_q[PAGE_W-1:0]), .wdata(wdata),
    .ridx(prog_idx), .rdata(buf_rdata), .rmask(cur_mask)
  );

  assign rd_go = rd_req && guard_n;

  nvw_array #(.AW(STORE_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(prog_we), .waddr({page_q[SPAGE_W-1:0], prog_idx}),
    .wdata(buf_rdata), .re(rd_go && !busy), .raddr(addr[STORE_W-1:0]),
    .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_stat  <= 1'b0;
      stat_q   <= '0;
      tog_q    <= 1'b1;
      last_q   <= '0;
    end else begin
      rd_valid <= rd_go;
      if (acc) last_q <= wdata;
      if (rd_go) begin
        rd_stat <= busy;
        if (busy) begin
          stat_q <= {~last_q[DATA_W-1], tog_q, last_q[DATA_W-3:0]};
          tog_q  <= ~tog_q;
        end
      end
      if (start) tog_q <= 1'b1;
    end
  end

  assign rd_data  = rd_stat ? stat_q : arr_rdata;
  assign busy_oe  = busy;
  assign busy_lvl = ~busy;

  AST_READ_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req && guard_n)); // R11
  AST_ARRAY_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |-> busy_oe); // R4
endmodule

// File: tb/nvw_page_writer_tb.sv
module nvw_page_writer_tb_top;
  localparam int LW = 20;
  localparam int PC = 200;
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {17'h00000, 8'hA5}, {17'h00001, 8'h5A}, {17'h0007F, 8'hC3},
    {17'h00080, 8'h81}, {17'h000C0, 8'h7E},
    {17'h002A4, 8'h11}, {17'h002FF, 8'hEE}, {17'h00280, 8'h40}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0, guard_n = 1'b1, wr_en = 1'b0, rd_req = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic rd_valid, busy_oe, busy_lvl, page_err;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nvw_page_writer #(.LOAD_WIN(LW), .PROG_CYC(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .guard_n(guard_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy_oe(busy_oe), .busy_lvl(busy_lvl), .page_err(page_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic [7:0] d, input logic t);
    return {~d[7], t, d[5:0]};
  endfunction

  task automatic wr2(input logic [16:0] a0, input logic [16:0] a1, input logic [7:0] d);
    wr_en = 1'b1; addr = a0; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = a1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    wr2(a, a, d);
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] d, output logic v);
    rd_req = 1'b1; addr = a;
    @(negedge clk);
    rd_req = 1'b0;
    d = rd_data; v = rd_valid;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_oe && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy_oe", busy_oe, 0);
    chk("R1 busy_lvl", busy_lvl, 1);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 page_err", page_err, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][24:8], VEC[i][7:0]);
      if (i == 0) chk("R2 busy after first byte", busy_oe, 1);
      if (i == NV - 1 || VEC[i+1][24:15] != VEC[i][24:15]) begin
        wait_idle(n);
        chk("R3 busy window", n, LW + PC);
      end
    end
    for (int i = 0; i < NV; i++) begin
      rd(VEC[i][24:8], d, v);
      chk("R11 valid", v, 1);
      chk("R4 readback", d, VEC[i][7:0]);
    end

    wr2(17'h00002, 17'h00001, 8'h99);
    rd(17'h00002, d, v);
    chk("R5 R6 first status", d, stat(8'h99, 1'b1));
    rd(17'h00002, d, v);
    chk("R6 second status", d, stat(8'h99, 1'b0));
    wait_idle(n);
    rd(17'h00002, d, v);
    chk("R2 data at start addr", d, 8'h99);
    rd(17'h00001, d, v);
    chk("R2 late addr unused", d, 8'h5A);

    wr(17'h00081, 8'h22);
    wr(17'h0007F, 8'h00);
    chk("R7 page_err pulse", page_err, 1);
    @(negedge clk);
    chk("R7 page_err single", page_err, 0);
    wait_idle(n);
    chk("R7 timer not restarted", n, LW + PC - 3);
    rd(17'h0007F, d, v);
    chk("R7 foreign byte dropped", d, 8'hC3);
    rd(17'h00081, d, v);
    chk("R4 page1 new byte", d, 8'h22);

    wr(17'h00000, 8'h77);
    repeat (LW + 2) @(negedge clk);
    rd(17'h00000, d, v);
    chk("R6 prog status first", d, stat(8'h77, 1'b1));
    rd(17'h00000, d, v);
    chk("R6 prog status second", d, stat(8'h77, 1'b0));
    wr(17'h0007F, 8'h12);
    chk("R8 still busy", busy_oe, 1);
    rd(17'h00000, d, v);
    chk("R8 status unchanged", d, stat(8'h77, 1'b1));
    wait_idle(n);
    rd(17'h00000, d, v);
    chk("R4 overwrite", d, 8'h77);
    rd(17'h0007F, d, v);
    chk("R8 ignored write", d, 8'hC3);

    guard_n = 1'b0;
    rd(17'h00280, d, v);
    chk("R9 no read when guarded", v, 0);
    wr(17'h00280, 8'hBB);
    chk("R9 no busy when guarded", busy_oe, 0);
    guard_n = 1'b1;
    @(negedge clk);
    rd(17'h00280, d, v);
    chk("R9 array unchanged", d, 8'h40);

    wr(17'h002A4, 8'h5F);
    wr(17'h00280, 8'h01);
    repeat (LW + 1) @(negedge clk);
    guard_n = 1'b0;
    @(negedge clk);
    chk("R10 abort releases busy", busy_oe, 0);
    guard_n = 1'b1;
    @(negedge clk);
    rd(17'h002A4, d, v);
    chk("R10 uncopied byte kept", d, 8'h11);
    rd(17'h00280, d, v);
    chk("R10 copied byte", d, 8'h01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule